// File: doc/BRIEF.md
# Host Bus Protocol Auto-Detector

This block sits at the entry of a parallel host port and works out which bus protocol the attached processor speaks. A board strap picks between a bus with separate address and data lines and a bus where address and data share the same wires. In the shared case, two timing variants exist, and the block tells them apart without any setup. It looks at the level of the data-strobe/read line at the moment the address strobe falls.

The strobe lines are asynchronous to the block clock, so they pass through a synchroniser before any edge is looked for. The first falling edge of the address strobe after reset fixes the variant. The result is then frozen until the next reset. A valid flag tells the downstream read/write decoder when the outputs can be trusted. With the strap low, the flag rises as soon as reset has been released. With the strap high, it rises once the first detection has been made.

Top module: `host_bus_detect`

## Requirements
- R1: While `rst_n` is low, `mode_valid_o`, `nonmux_o` and `mux_timing_o` are all 0, and they go to 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: Reset release is synchronised. After `rst_n` rises, all three outputs stay 0 through the first two rising clock edges.
- R3: If `strap_mux_i` is 0 at the third rising edge after reset release, `nonmux_o` and `mode_valid_o` become 1 after that edge, and `mux_timing_o` stays 0.
- R4: If `strap_mux_i` is 1 at that edge, `mode_valid_o` stays 0 until a detection has been made. While `mode_valid_o` is 0, `nonmux_o` and `mux_timing_o` are 0.
- R5: In shared-bus mode, a falling edge of `as_ale_i` is detected after a two-stage synchroniser. Take the strobe as low first at rising edge k, having been high at edge k-1. If `ds_rd_i` is 1 at edge k, then after edge k+2 `mode_valid_o` is 1 and `mux_timing_o` is 0 (timing variant 1).
- R6: Under the same conditions, if `ds_rd_i` is 0 at edge k, then `mux_timing_o` is 1 (timing variant 2).
- R7: A rising edge of `as_ale_i`, or a strobe held at a constant level, causes no detection. Strobe activity in non-shared mode does not change any output.
- R8: Once `mode_valid_o` is 1, all outputs hold their values until the next reset. Later strobe edges and changes of `strap_mux_i` or `ds_rd_i` have no effect.
- R9: A new reset clears the stored mode, and the next detection can give a different result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_mux_i | input | 1 | Board strap: 0 = separate address/data bus, 1 = shared address/data bus |
| as_ale_i | input | 1 | Address strobe / address latch enable from the host, asynchronous |
| ds_rd_i | input | 1 | Data strobe / read strobe from the host, asynchronous |
| nonmux_o | output | 1 | 1 when the separate address/data protocol is in use |
| mux_timing_o | output | 1 | Shared-bus variant: 0 = variant 1 (strobe high), 1 = variant 2 (strobe low) |
| mode_valid_o | output | 1 | 1 once the protocol decision is final |

## Verification
The detector is driven through several sequences, each followed by a reset:
- With the strap low, the strobes are toggled freely. This separates the strap decision from any strobe activity.
- With the strap high, a strobe that only rises or stays constant is applied before a real falling edge. This shows that only a high-to-low transition triggers capture.
- The falling edge is repeated once with the data strobe high and once with it low. This tells the two timing variants apart.
- After lock, contradictory edges and a strap flip are applied. A one-cycle strobe pulse is used to show that the synchroniser passes it.

The exact edge on which the valid flag rises is compared against an independent cycle model. This exposes any added or missing register stage.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [1:0] {
    ST_DECIDE  = 2'd0,
    ST_WAIT_AS = 2'd1,
    ST_LOCK_NM = 2'd2,
    ST_LOCK_MX = 2'd3
  } hbd_state_e;

  typedef enum logic {
    TM_DS_HIGH = 1'b0,
    TM_DS_LOW  = 1'b1
  } hbd_timing_e;

  localparam int unsigned HBD_MIN_STAGES = 2;

endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  // next-state: every stage takes the one before it
  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < int'(STAGES); i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hbd_fall_det.sv
module hbd_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
    end
  end

  assign fall_o = prev_q & ~sig_i;

endmodule

// File: rtl/hbd_mode_fsm.sv
module hbd_mode_fsm
  import hbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  input  logic as_fall_i,
  input  logic ds_lvl_i,
  output logic nonmux_o,
  output logic timing_o,
  output logic valid_o
);

  hbd_state_e  state_q, state_d;
  hbd_timing_e tm_q, tm_d;
  logic        tm_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    tm_en   = 1'b0;
    tm_d    = ds_lvl_i ? TM_DS_HIGH : TM_DS_LOW;
    case (state_q)
      ST_DECIDE:  state_d = strap_i ? ST_WAIT_AS : ST_LOCK_NM;
      ST_WAIT_AS: begin
        if (as_fall_i) begin
          state_d = ST_LOCK_MX;
          tm_en   = 1'b1;
        end
      end
      default:    state_d = state_q;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DECIDE;
    end else begin
      state_q <= state_d;
    end
  end

  // timing register, loaded only on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q <= TM_DS_HIGH;
    end else if (tm_en) begin
      tm_q <= tm_d;
    end
  end

  assign nonmux_o = (state_q == ST_LOCK_NM);
  assign valid_o  = (state_q == ST_LOCK_NM) || (state_q == ST_LOCK_MX);
  assign timing_o = (tm_q == TM_DS_LOW);

endmodule

// File: rtl/host_bus_detect.sv
module host_bus_detect #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_mux_i,
  input  logic as_ale_i,
  input  logic ds_rd_i,
  output logic nonmux_o,
  output logic mux_timing_o,
  output logic mode_valid_o
);

  localparam int unsigned SYNC_W   = 2;
  localparam int unsigned BIT_AS   = 0;
  localparam int unsigned BIT_DS   = 1;

  logic              rst_int_n;
  logic [SYNC_W-1:0] strobe_raw;
  logic [SYNC_W-1:0] strobe_syn;
  logic              as_fall;

  hbd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign strobe_raw[BIT_AS] = as_ale_i;
  assign strobe_raw[BIT_DS] = ds_rd_i;

  hbd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (strobe_raw),
    .q_o   (strobe_syn)
  );

  hbd_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  (strobe_syn[BIT_AS]),
    .fall_o (as_fall)
  );

  hbd_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strap_i   (strap_mux_i),
    .as_fall_i (as_fall),
    .ds_lvl_i  (strobe_syn[BIT_DS]),
    .nonmux_o  (nonmux_o),
    .timing_o  (mux_timing_o),
    .valid_o   (mode_valid_o)
  );

endmodule

// File: rtl/host_bus_detect_chk.sv
module host_bus_detect_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic strap_mux_i,
  input logic as_ale_i,
  input logic ds_rd_i,
  input logic nonmux_o,
  input logic mux_timing_o,
  input logic mode_valid_o
);

  localparam int unsigned QUIET = RST_STAGES + 1;
  localparam int unsigned CW    = $clog2(QUIET + 1);

  logic [CW-1:0] since_rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rel_q <= '0;
    end else if (since_rel_q != CW'(QUIET)) begin
      since_rel_q <= since_rel_q + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mode_valid_o && !nonmux_o && !mux_timing_o));

  assert_release_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rel_q < CW'(QUIET)) |-> !mode_valid_o);

  assert_strap_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mode_valid_o) && nonmux_o) |-> !$past(strap_mux_i));

  assert_nonmux_implies_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nonmux_o |-> mode_valid_o);

  assert_idle_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid_o |-> (!nonmux_o && !mux_timing_o));

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_o |=> (mode_valid_o && $stable(nonmux_o) && $stable(mux_timing_o)));

  generate
    if (SYNC_STAGES == 2) begin : g_lat2
      // R5 / R6: capture follows a real high-to-low strobe, variant from data strobe
      assert_capture_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_valid_o) && !nonmux_o) |->
          (!$past(as_ale_i, 3) && $past(as_ale_i, 4)));
      assert_capture_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_valid_o) && !nonmux_o) |->
          (mux_timing_o == !$past(ds_rd_i, 3)));
    end
  endgenerate

endmodule

bind host_bus_detect host_bus_detect_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .RST_STAGES (RST_STAGES)
) i_chk (.*);

// File: tb/test_host_bus_detect.sv
`timescale 1ns/100ps
module test_host_bus_detect;

  localparam int SYNC = 2;
  localparam int RSTS = 2;

  logic clk;
  logic rst_n;
  logic strap_mux_i;
  logic as_ale_i;
  logic ds_rd_i;
  logic nonmux_o;
  logic mux_timing_o;
  logic mode_valid_o;

  int errors;
  int checks;
  string phase;
  bit done;

  host_bus_detect #(.SYNC_STAGES(SYNC), .RST_STAGES(RSTS)) i_host_bus_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_mux_i  (strap_mux_i),
    .as_ale_i     (as_ale_i),
    .ds_rd_i      (ds_rd_i),
    .nonmux_o     (nonmux_o),
    .mux_timing_o (mux_timing_o),
    .mode_valid_o (mode_valid_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  int   m_rel;     // edges since reset release
  int   m_mode;    // 0 deciding, 1 waiting, 2 separate bus, 3 shared bus
  bit   m_tim;
  bit   as_h[$];   // sampled strobe history, oldest first
  bit   ds_h[$];

  task automatic model_clear();
    as_h.delete();
    ds_h.delete();
    for (int i = 0; i <= SYNC; i++) begin
      as_h.push_back(1'b0);
      ds_h.push_back(1'b0);
    end
    m_mode = 0;
    m_tim  = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0;
      model_clear();
    end else if (m_rel < RSTS) begin
      m_rel++;
      model_clear();
    end else begin
      bit fell;
      fell = as_h[0] && !as_h[1];
      case (m_mode)
        0: m_mode = strap_mux_i ? 1 : 2;
        1: if (fell) begin m_mode = 3; m_tim = !ds_h[1]; end
        default: ;
      endcase
      as_h.push_back(as_ale_i); void'(as_h.pop_front());
      ds_h.push_back(ds_rd_i);  void'(ds_h.pop_front());
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic ev, en, et;
      ev = rst_n && (m_mode >= 2);
      en = rst_n && (m_mode == 2);
      et = rst_n && (m_mode == 3) && m_tim;
      check(phase, "mode_valid_o", mode_valid_o, ev);
      check(phase, "nonmux_o", nonmux_o, en);
      check(phase, "mux_timing_o", mux_timing_o, et);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(logic strap, logic as_v, logic ds_v);
    rst_n = 1'b0;
    strap_mux_i = strap;
    as_ale_i = as_v;
    ds_rd_i = ds_v;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; done = 1'b0;
    phase = "R1";
    rst_n = 1'b0; strap_mux_i = 1'b0; as_ale_i = 1'b1; ds_rd_i = 1'b1;
    tick(3);
    check("R1", "valid in reset", mode_valid_o, 1'b0);
    check("R1", "nonmux in reset", nonmux_o, 1'b0);

    // separate bus: strap low
    phase = "R2";
    rst_n = 1'b1;
    tick(2);
    check("R2", "valid after two edges", mode_valid_o, 1'b0);
    phase = "R3";
    tick(1);
    check("R3", "valid after third edge", mode_valid_o, 1'b1);
    check("R3", "nonmux after third edge", nonmux_o, 1'b1);
    check("R3", "timing in separate mode", mux_timing_o, 1'b0);

    phase = "R7";
    ds_rd_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      as_ale_i = ~as_ale_i;
      tick(2);
    end
    check("R7", "nonmux after strobes", nonmux_o, 1'b1);
    check("R7", "timing after strobes", mux_timing_o, 1'b0);

    // async reset drop mid-operation
    phase = "R1";
    rst_n = 1'b0;
    #0.5;
    check("R1", "valid right after async reset", mode_valid_o, 1'b0);
    check("R1", "nonmux right after async reset", nonmux_o, 1'b0);

    // shared bus, strobe low at release, only rises first
    phase = "R4";
    do_reset(1'b1, 1'b0, 1'b1);
    tick(3);
    check("R4", "valid waits for strobe", mode_valid_o, 1'b0);
    check("R4", "nonmux with strap high", nonmux_o, 1'b0);
    phase = "R7";
    as_ale_i = 1'b1;
    tick(8);
    check("R7", "no capture on rising edge", mode_valid_o, 1'b0);
    phase = "R5";
    as_ale_i = 1'b0;
    tick(2);
    check("R5", "valid two edges after fall", mode_valid_o, 1'b0);
    tick(1);
    check("R5", "valid three edges after fall", mode_valid_o, 1'b1);
    check("R5", "variant 1 with data strobe high", mux_timing_o, 1'b0);

    phase = "R8";
    ds_rd_i = 1'b0; strap_mux_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      as_ale_i = ~as_ale_i;
      tick(3);
    end
    check("R8", "timing held after lock", mux_timing_o, 1'b0);
    check("R8", "nonmux held after lock", nonmux_o, 1'b0);
    check("R8", "valid held after lock", mode_valid_o, 1'b1);

    // new reset, variant 2 via a one-cycle pulse
    phase = "R9";
    do_reset(1'b1, 1'b0, 1'b0);
    tick(3);
    check("R9", "mode cleared by reset", mode_valid_o, 1'b0);
    phase = "R6";
    tick(4);
    as_ale_i = 1'b1;
    tick(1);
    as_ale_i = 1'b0;
    tick(2);
    check("R6", "valid two edges after fall", mode_valid_o, 1'b0);
    tick(1);
    check("R6", "valid three edges after fall", mode_valid_o, 1'b1);
    check("R6", "variant 2 with data strobe low", mux_timing_o, 1'b1);
    check("R9", "redetection differs", mux_timing_o, 1'b1);

    // strobe held high in shared mode, then fall with data strobe high
    phase = "R7";
    do_reset(1'b1, 1'b1, 1'b1);
    tick(10);
    check("R7", "constant strobe no capture", mode_valid_o, 1'b0);
    phase = "R5";
    as_ale_i = 1'b0;
    tick(3);
    check("R5", "capture from idle-high strobe", mode_valid_o, 1'b1);
    check("R5", "variant 1 again", mux_timing_o, 1'b0);
    tick(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule